// File: doc/BRIEF.md
# Latched 64-bit Match Timer

This block is a system timer that sits on a simple synchronous 32-bit register bus with word addresses. A prescaler turns the input clock into advance ticks, and each tick steps a free-running 64-bit up-counter. Six 32-bit compare channels watch the low word of the counter. Each channel sets a sticky status flag when it hits. Software clears a flag by writing a one to it.

The status flags, masked by a per-channel enable, are combined into one registered interrupt line. Channel 0 is meant for one-shot event programming. The last channel can also arm a one-clock reset pulse, which serves as a watchdog.

A 64-bit value cannot be read in one 32-bit access without tearing. Software therefore writes a snapshot command, which copies the whole counter into two read-only words in a single clock. It then reads those two words at leisure.

Top module: `tmr_latched_timer`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero and both `irq` and `wdt_rst` are low.
- R2: A write of a value with bit 0 set to word 12 copies all 64 counter bits, as they stand before that edge, into the snapshot words: word 13 gets the low half and word 14 the high half. The snapshot holds until the next such write. A write to word 12 with bit 0 clear, and any write to word 13 or 14, leaves the snapshot unchanged.
- R3: The counter wraps modulo 2^64, so 0xFFFFFFFF_FFFFFFFF advances to zero with the carry crossing the 32-bit halves.
- R4: A write to word 0 loads the counter's low half and a write to word 1 loads its high half. A load wins over an advance in the same cycle, and both words read back the live count.
- R5: With divider word 11 holding D, the counter advances once every 2*(D+1) clocks. A write to word 11 restarts the prescale phase, and the counter does not advance in that cycle, so the first advance comes 2*(D+1) clocks after the write.
- R6: Words 2 to 7 hold compare values for channels 0 to 5. Bit n of status word 8 is set in the clock after the counter advances to a value whose low half equals channel n's compare value, and the bit stays set. A compare value written equal to a count that is merely held, or that was just loaded, does not set the bit.
- R7: Writing word 8 clears each status bit whose write-data bit is 1. Bits written as 0 are untouched.
- R8: `irq` is high one clock after any status bit n is set while bit n of enable word 9 is set. It is low one clock after no enabled status bit remains.
- R9: When bit 0 of word 10 is set and channel 5 hits, `wdt_rst` is high for exactly one clock, in the same clock its status bit rises. With that bit clear, channel 5 still sets its status bit but gives no pulse.
- R10: Reading word 12 or words 15 and above returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| irq | output | 1 | Registered OR of enabled status flags |
| wdt_rst | output | 1 | One-clock watchdog reset pulse |

## Verification
The bench goes after exact prescaler timing. A design that forgot the factor of two, or let a divider write also advance the count, would snapshot a value that is off by one or more. It drives the counter through the all-ones wrap. A carry that fails to reach the high half shows up as a wrong upper snapshot word.

It writes a compare value equal to a held count. A comparator that fires continuously, rather than on advances only, would set that status bit early. It writes zero bits to the status word; a design that treats status as a plain register would lose flags there. It also counts watchdog pulses with the arm bit set and with it clear, which catches a level output in place of a pulse, and a pulse that ignores the arm bit.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int DW    = 32;
    localparam int CNT_W = 64;
    localparam int NCH   = 6;
    localparam int AW    = 4;
    localparam int DIV_W = 16;

    typedef enum logic [3:0] {
        RA_CNT_LO = 4'd0,
        RA_CNT_HI = 4'd1,
        RA_CMP0   = 4'd2,
        RA_STATUS = 4'd8,
        RA_IEN    = 4'd9,
        RA_WDEN   = 4'd10,
        RA_DIV    = 4'd11,
        RA_SNAP   = 4'd12,
        RA_SNP_LO = 4'd13,
        RA_SNP_HI = 4'd14
    } reg_addr_e;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_req_t;

    function automatic logic wr_hit(bus_req_t r, reg_addr_e a);
        return r.wr && (r.addr == a);
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
    parameter int PS_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PS_W-1:0] div,
    input  logic            restart,
    output logic            tick
);
    localparam int PC_W = PS_W + 1;

    logic [PC_W-1:0] phase_q;

    // terminal phase is 2*D+1, i.e. the divider with a one appended
    assign tick = (phase_q == {div, 1'b1}) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || tick) phase_q <= '0;
        else                        phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
    parameter int CW = 64,
    parameter int HW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [HW-1:0] ld_data,
    output logic [CW-1:0] cnt,
    output logic          adv
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            adv <= 1'b0;
        end else begin
            adv <= tick && !ld_lo && !ld_hi;
            if (ld_lo)      cnt[HW-1:0]  <= ld_data;
            else if (ld_hi) cnt[CW-1:HW] <= ld_data;
            else if (tick)  cnt          <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_match_bank.sv
`timescale 1ns/1ps
module tmr_match_bank #(
    parameter int N  = 6,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  logic [DW-1:0]        cnt_lo,
    input  logic [N-1:0]         cmp_we,
    input  logic [DW-1:0]        wdata,
    input  logic [N-1:0]         clr,
    output logic [N-1:0][DW-1:0] cmp,
    output logic [N-1:0]         hit,
    output logic [N-1:0]         status
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        assign hit[i] = adv && (cnt_lo == cmp[i]);

        always_ff @(posedge clk) begin
            if (rst) begin
                cmp[i]    <= '0;
                status[i] <= 1'b0;
            end else begin
                if (cmp_we[i]) cmp[i] <= wdata;
                // a hit in the same cycle as a clear wins
                status[i] <= (status[i] && !clr[i]) || hit[i];
            end
        end
    end
endmodule

// File: rtl/tmr_latched_timer.sv
`timescale 1ns/1ps
module tmr_latched_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = NCH,
    parameter int PS_W   = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          wdt_rst
);
    localparam int WDT_CH = NUM_CH - 1;

    bus_req_t req;
    assign req = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    logic                     tick, adv;
    logic [CNT_W-1:0]         cnt_q;
    logic [CNT_W-1:0]         lat_q;
    logic [PS_W-1:0]          div_q;
    logic [NUM_CH-1:0]        ien_q;
    logic                     wden_q;
    logic                     irq_q, wdt_q;
    logic [NUM_CH-1:0]        cmp_we, clr, hit, status_q;
    logic [NUM_CH-1:0][DW-1:0] cmp_v;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_we
        assign cmp_we[i] = req.wr && (req.addr == AW'(int'(RA_CMP0) + i));
    end
    assign clr = wr_hit(req, RA_STATUS) ? req.data[NUM_CH-1:0] : '0;

    tmr_prescaler #(.PS_W(PS_W)) u_ps (
        .clk     (clk),
        .rst     (rst),
        .div     (div_q),
        .restart (wr_hit(req, RA_DIV)),
        .tick    (tick)
    );

    tmr_counter #(.CW(CNT_W), .HW(DW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .ld_lo   (wr_hit(req, RA_CNT_LO)),
        .ld_hi   (wr_hit(req, RA_CNT_HI)),
        .ld_data (req.data),
        .cnt     (cnt_q),
        .adv     (adv)
    );

    tmr_match_bank #(.N(NUM_CH), .DW(DW)) u_mb (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .cnt_lo (cnt_q[DW-1:0]),
        .cmp_we (cmp_we),
        .wdata  (req.data),
        .clr    (clr),
        .cmp    (cmp_v),
        .hit    (hit),
        .status (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q  <= '0;
            div_q  <= '0;
            ien_q  <= '0;
            wden_q <= 1'b0;
            irq_q  <= 1'b0;
            wdt_q  <= 1'b0;
        end else begin
            if (wr_hit(req, RA_SNAP) && req.data[0]) lat_q <= cnt_q;
            if (wr_hit(req, RA_DIV))  div_q  <= req.data[PS_W-1:0];
            if (wr_hit(req, RA_IEN))  ien_q  <= req.data[NUM_CH-1:0];
            if (wr_hit(req, RA_WDEN)) wden_q <= req.data[0];
            irq_q <= |(status_q & ien_q);
            wdt_q <= wden_q && hit[WDT_CH];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (req.addr)
            RA_CNT_LO: bus_rdata = cnt_q[DW-1:0];
            RA_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DW];
            RA_STATUS: bus_rdata = DW'(status_q);
            RA_IEN:    bus_rdata = DW'(ien_q);
            RA_WDEN:   bus_rdata = DW'(wden_q);
            RA_DIV:    bus_rdata = DW'(div_q);
            RA_SNP_LO: bus_rdata = lat_q[DW-1:0];
            RA_SNP_HI: bus_rdata = lat_q[CNT_W-1:DW];
            default: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (req.addr == AW'(int'(RA_CMP0) + i)) bus_rdata = cmp_v[i];
            end
        endcase
    end

    assign irq     = irq_q;
    assign wdt_rst = wdt_q;
endmodule

// File: rtl/tmr_latched_timer_chk.sv
`timescale 1ns/1ps
module tmr_latched_timer_chk
    import tmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lat,
    input logic [NCH-1:0]   status,
    input logic             wden,
    input logic             irq,
    input logic             wdt_rst
);
    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((cnt != $past(cnt)) &&
         !$past(bus_wr && (bus_addr == RA_CNT_LO || bus_addr == RA_CNT_HI)))
        |-> (cnt == $past(cnt) + 64'd1));

    // R2
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr && bus_addr == RA_SNAP && bus_wdata[0]) |-> $stable(lat));

    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(status) & ~status) != '0) |-> $past(bus_wr && bus_addr == RA_STATUS));

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(status) != '0));

    // R9
    wdt_width_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

    // R9
    wdt_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> (status[NCH-1] && $past(wden)));
endmodule

bind tmr_latched_timer tmr_latched_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_q),
    .lat       (lat_q),
    .status    (status_q),
    .wden      (wden_q),
    .irq       (irq),
    .wdt_rst   (wdt_rst)
);

// File: tb/tb_tmr_latched_timer.sv
`timescale 1ns/1ps
module tb_tmr_latched_timer;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wdt_rst;

    always #2.5 clk = ~clk;

    tmr_latched_timer dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdt_rst(wdt_rst)
    );

    int          n_tests = 0;
    int          n_fail = 0;
    int          wdt_pulses = 0;
    logic        rd_pend = 1'b0;
    logic        done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data while a read is on the bus
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        if (!rst && wdt_rst) wdt_pulses++;
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(posedge clk); #1;
        rd_pend = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] e, string tag);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        rd_pend = 1'b1;
    endtask

    task automatic idle(int n);
        @(posedge clk); #1;
        rd_pend = 1'b0; bus_wr = 1'b0;
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(RA_CNT_HI, 32'h0, "R1 counter high");
        rd(RA_STATUS, 32'h0, "R1 status");
        rd(RA_IEN,    32'h0, "R1 enable");
        rd(RA_DIV,    32'h0, "R1 divider");
        rd(RA_SNP_LO, 32'h0, "R1 snapshot low");
        @(negedge clk);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 wdt_rst", 32'(wdt_rst), 32'h0);

        // R4 load and read back, slow prescaler keeps the count still
        wr(RA_DIV, 32'd1000);
        wr(RA_CNT_LO, 32'hABCD0000);
        wr(RA_CNT_HI, 32'h12345678);
        rd(RA_CNT_HI, 32'h12345678, "R4 high readback");
        rd(RA_CNT_LO, 32'hABCD0000, "R4 low readback");

        // R5 divider 3: advances 8 and 16 clocks after the divider write
        wr(RA_CNT_LO, 32'h10);
        wr(RA_CNT_HI, 32'h1);
        wr(RA_DIV, 32'd3);
        idle(18);
        wr(RA_SNAP, 32'h1);
        rd(RA_SNP_HI, 32'h1,  "R5 snapshot high");
        rd(RA_SNP_LO, 32'h12, "R5 snapshot low");
        idle(12);
        rd(RA_SNP_LO, 32'h12, "R2 snapshot holds");

        // R3 wrap with divider 0: two advances before the snapshot
        wr(RA_CNT_LO, 32'hFFFFFFFF);
        wr(RA_CNT_HI, 32'hFFFFFFFF);
        wr(RA_DIV, 32'd0);
        idle(4);
        wr(RA_SNAP, 32'h1);
        rd(RA_SNP_HI, 32'h0, "R3 wrap high");
        rd(RA_SNP_LO, 32'h1, "R3 wrap low");
        wr(RA_SNAP, 32'h0);
        idle(4);
        rd(RA_SNP_LO, 32'h1, "R2 bit0 clear no snapshot");

        // R10 unused words, R2 read-only snapshot
        rd(4'd12, 32'h0, "R10 command word");
        rd(4'd15, 32'h0, "R10 unused word");
        wr(RA_SNP_LO, 32'hDEAD);
        wr(RA_SNP_HI, 32'hBEEF);
        rd(RA_SNP_LO, 32'h1, "R2 snapshot low write ignored");
        rd(RA_SNP_HI, 32'h0, "R2 snapshot high write ignored");

        // R6 / R8 match on advance
        wr(4'd2, 32'd103);
        wr(4'd3, 32'd104);
        wr(RA_IEN, 32'h1);
        wr(RA_STATUS, 32'h3F);
        wr(RA_CNT_LO, 32'd100);
        wr(RA_CNT_HI, 32'd0);
        wr(RA_DIV, 32'd0);
        idle(20);
        rd(RA_STATUS, 32'h3, "R6 sticky status");
        @(negedge clk);
        chk("R8 irq set", 32'(irq), 32'h1);

        // R7 write-one-to-clear
        wr(RA_STATUS, 32'h0);
        rd(RA_STATUS, 32'h3, "R7 zero write no effect");
        wr(RA_STATUS, 32'h1);
        rd(RA_STATUS, 32'h2, "R7 one clears bit");
        idle(2);
        @(negedge clk);
        chk("R8 disabled bit masked", 32'(irq), 32'h0);
        wr(RA_IEN, 32'h3);
        idle(2);
        @(negedge clk);
        chk("R8 enabled bit raises", 32'(irq), 32'h1);
        wr(RA_STATUS, 32'h3F);
        wr(RA_IEN, 32'h0);
        idle(2);
        @(negedge clk);
        chk("R8 irq drops", 32'(irq), 32'h0);

        // R6 compare written equal to a held count
        wr(RA_DIV, 32'd1000);
        wr(RA_CNT_LO, 32'd500);
        wr(4'd4, 32'd500);
        idle(40);
        rd(RA_STATUS, 32'h0, "R6 held count no match");

        // R9 watchdog armed
        wr(4'd7, 32'd203);
        wr(RA_WDEN, 32'h1);
        wr(RA_CNT_LO, 32'd200);
        wr(RA_CNT_HI, 32'd0);
        wr(RA_DIV, 32'd0);
        idle(20);
        chk("R9 one pulse armed", 32'(wdt_pulses), 32'd1);
        rd(RA_STATUS, 32'h20, "R9 channel 5 status");

        // R9 watchdog disarmed
        wr(RA_STATUS, 32'h3F);
        wr(RA_WDEN, 32'h0);
        wr(4'd7, 32'd205);
        wr(RA_CNT_LO, 32'd200);
        wr(RA_DIV, 32'd0);
        idle(20);
        chk("R9 no pulse disarmed", 32'(wdt_pulses), 32'd1);
        rd(RA_STATUS, 32'h20, "R9 status still set");

        idle(2);
        chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule